// File: doc/BRIEF.md
# Parallel single-wire LED data driver with stall-proof pulse timing

This block drives several single-wire addressable LED data lines in lockstep. Every bit on every lane starts with a high pulse whose width encodes the value: a short pulse for 0 and a long pulse for 1. A low phase follows until the bit period is complete. All pulse edges are timed from a free-running reference counter. The counter advances every clock whatever the pixel source is doing, so a slow source can never widen a pulse.

Pixel data arrives through a valid/ready fetch port. Each transfer carries one 24-bit word per lane. The port can stall for any number of cycles. Ready is raised only in the gap after the last bit of a pixel, while every lane is low, so a stall can only lengthen that gap. If a stall runs past an underrun limit, the frame is cut. The lanes are then held low for the latch time and the frame is resent from pixel 0 without a new start. A clean frame ends with the latch-low period and a one-cycle done pulse.

Top module: `led_par_driver`

## Requirements
- R1: While reset is held and after it is released, `lane_o`, `busy_o`, `fetch_ready_o`, `done_o` and `underrun_o` are all 0.
- R2: A 0 bit holds a lane high for exactly T0H_CYC cycles and a 1 bit for exactly T1H_CYC cycles. Within a pixel, consecutive rising edges lie exactly BIT_CYC cycles apart.
- R3: Each lane sends the 24-bit word it received, most significant bit first. Lane k takes bits [24k+23:24k] of `fetch_data_i`, and the words go out in the order of the pixel index `fetch_idx_o`.
- R4: All lanes rise in the same cycle at the start of every bit.
- R5: `fetch_ready_o` is high only while the block is busy and every lane is low. A word is taken on a cycle with `fetch_valid_i` and `fetch_ready_o` both high.
- R6: However long the fetch port stalls (below the underrun limit), pulse widths stay as in R2; only the low gap between pixels grows.
- R7: If no word arrives within UND_CYC cycles of ready rising, `underrun_o` pulses for one cycle and all lanes stay low for RST_CYC cycles. Ready then rises again with `fetch_idx_o` = 0 and the frame is resent from pixel 0.
- R8: After the last bit period of the last pixel, all lanes stay low for RST_CYC cycles. Then `done_o` is high for exactly one cycle while `busy_o` is low. Done therefore comes BIT_CYC+RST_CYC-1 cycles after the last rising edge.
- R9: `start_i` has no effect while busy, and a start with `pix_count_i` = 0 leaves the block idle.
- R10: `busy_o` rises in the cycle after an accepted start and stays high until the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the reference counter runs on it |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-of-frame strobe |
| pix_count_i | input | CNT_W | Pixels per lane, latched at start |
| fetch_valid_i | input | 1 | Pixel word available |
| fetch_data_i | input | LANES*24 | One 24-bit word per lane |
| fetch_ready_o | output | 1 | Block takes a word this cycle if valid |
| fetch_idx_o | output | CNT_W | Index of the pixel being requested |
| lane_o | output | LANES | Serial data lines |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame completion |
| underrun_o | output | 1 | One-cycle pulse when a fetch exceeded the limit |

## Verification
A wrong phase stamp or threshold shows up within one bit period as a pulse whose width is neither T0H nor T1H, or as a rise-to-rise spacing other than BIT_CYC. A stuck bit or pixel counter shows up as a decoded word that differs from the table entry at the end of the first pixel, or as a wrong pixel count or done time at frame end. Random stalls at the fetch port expose any path by which the source could stretch a high phase. A hung fetch exposes errors in the underrun timing and the restart index within one UND_CYC+RST_CYC window.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_BIT,
    ST_RST
  } drv_state_e;
endpackage

// File: rtl/led_ref_timer.sv
// Free-running reference counter; elapsed_o counts cycles since the last restart.
module led_ref_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  output logic [TW-1:0] elapsed_o
);
  logic [TW-1:0] ref_q, stamp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q   <= '0;
      stamp_q <= '0;
    end else begin
      ref_q <= ref_q + 1'b1;
      if (restart_i) stamp_q <= ref_q + 1'b1;
    end
  end

  assign elapsed_o = ref_q - stamp_q;
endmodule

// File: rtl/led_lane.sv
module led_lane #(
  parameter int PIX_W = 24,
  parameter int TW    = 16,
  parameter int T0H   = 70,
  parameter int T1H   = 140
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PIX_W-1:0] data_i,
  input  logic             shift_i,
  input  logic             active_i,
  input  logic [TW-1:0]    elapsed_i,
  output logic             lane_o
);
  localparam logic [TW-1:0] T0H_C = TW'(T0H);
  localparam logic [TW-1:0] T1H_C = TW'(T1H);

  logic [PIX_W-1:0] sh_q;
  logic [TW-1:0]    thr;
  logic             lane_q;

  assign thr = sh_q[PIX_W-1] ? T1H_C : T0H_C;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      lane_q <= 1'b0;
    end else begin
      if (load_i)       sh_q <= data_i;
      else if (shift_i) sh_q <= {sh_q[PIX_W-2:0], 1'b0};
      // registered so every edge sits exactly on the reference grid
      lane_q <= active_i && (elapsed_i < thr);
    end
  end

  assign lane_o = lane_q;
endmodule

// File: rtl/led_par_driver.sv
module led_par_driver
  import led_drv_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int PIX_W   = 24,
  parameter int CNT_W   = 16,
  parameter int T0H     = 70,
  parameter int T1H     = 140,
  parameter int BIT_CYC = 250,
  parameter int UND_CYC = 8000,
  parameter int RST_CYC = 10000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [CNT_W-1:0]       pix_count_i,
  input  logic                   fetch_valid_i,
  input  logic [LANES*PIX_W-1:0] fetch_data_i,
  output logic                   fetch_ready_o,
  output logic [CNT_W-1:0]       fetch_idx_o,
  output logic [LANES-1:0]       lane_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   underrun_o
);
  localparam int MAX_A   = (UND_CYC > RST_CYC) ? UND_CYC : RST_CYC;
  localparam int MAX_CYC = (MAX_A > BIT_CYC) ? MAX_A : BIT_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1) + 1;
  localparam int BW      = $clog2(PIX_W);
  localparam logic [TW-1:0] BIT_LAST = TW'(BIT_CYC - 1);
  localparam logic [TW-1:0] UND_LAST = TW'(UND_CYC - 1);
  localparam logic [TW-1:0] RST_LAST = TW'(RST_CYC - 1);
  localparam logic [BW-1:0] BIT_TOP  = BW'(PIX_W - 1);

  drv_state_e       state_q, state_d;
  logic [BW-1:0]    bit_q, bit_d;
  logic [CNT_W-1:0] pix_q, pix_d, cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             done_d, undr_d, done_q, undr_q;
  logic [TW-1:0]    elapsed;
  logic             bit_end, restart, load;

  led_ref_timer #(.TW(TW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .elapsed_o(elapsed)
  );

  assign bit_end = (state_q == ST_BIT) && (elapsed == BIT_LAST);
  assign load    = (state_q == ST_FETCH) && fetch_valid_i;
  assign restart = (state_d != state_q) || bit_end;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    pix_d   = pix_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    done_d  = 1'b0;
    undr_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i && (pix_count_i != '0)) begin
          state_d = ST_FETCH;
          pix_d   = '0;
          cnt_d   = pix_count_i;
        end
      end
      ST_FETCH: begin
        if (fetch_valid_i) begin
          state_d = ST_BIT;
          bit_d   = '0;
        end else if (elapsed == UND_LAST) begin
          state_d = ST_RST;
          pend_d  = 1'b1;
          undr_d  = 1'b1;
        end
      end
      ST_BIT: begin
        if (bit_end) begin
          if (bit_q == BIT_TOP) begin
            if (pix_q == cnt_q - 1'b1) begin
              state_d = ST_RST;
            end else begin
              state_d = ST_FETCH;
              pix_d   = pix_q + 1'b1;
            end
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
      end
      ST_RST: begin
        if (elapsed == RST_LAST) begin
          if (pend_q) begin
            state_d = ST_FETCH;
            pix_d   = '0;
            pend_d  = 1'b0;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      pix_q   <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      undr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      pix_q   <= pix_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
      undr_q  <= undr_d;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    led_lane #(
      .PIX_W(PIX_W),
      .TW   (TW),
      .T0H  (T0H),
      .T1H  (T1H)
    ) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load),
      .data_i   (fetch_data_i[g*PIX_W +: PIX_W]),
      .shift_i  (bit_end),
      .active_i (state_q == ST_BIT),
      .elapsed_i(elapsed),
      .lane_o   (lane_o[g])
    );
  end

  assign fetch_ready_o = (state_q == ST_FETCH);
  assign fetch_idx_o   = pix_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign underrun_o    = undr_q;
endmodule

// File: rtl/led_par_driver_chk.sv
module led_par_driver_chk #(
  parameter int LANES = 4,
  parameter int T1H   = 140
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fetch_ready_o,
  input logic [LANES-1:0] lane_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             underrun_o
);
  localparam int RW = $clog2(T1H + 2) + 1;
  localparam logic [RW-1:0] RUN_MAX = RW'(T1H + 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          run_q <= '0;
    else if (lane_o == '0)                run_q <= '0;
    else if (run_q != RUN_MAX)            run_q <= run_q + 1'b1;
  end

  AST_PULSE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RW'(T1H)); // R6
  AST_READY_LANES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_ready_o |-> (lane_o == '0)); // R5
  AST_READY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_ready_o |-> busy_o); // R5
  AST_LOCKSTEP_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lane_o != '0) && ($past(lane_o) == '0)) |-> (lane_o == '1)); // R4
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (lane_o == '0)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_UNDERRUN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> (busy_o && !fetch_ready_o && (lane_o == '0))); // R7
endmodule

bind led_par_driver led_par_driver_chk #(
  .LANES(LANES),
  .T1H  (T1H)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fetch_ready_o(fetch_ready_o),
  .lane_o       (lane_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .underrun_o   (underrun_o)
);

// File: tb/sim_led_par_driver.sv
module sim_led_par_driver;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 3;
  localparam int PW    = 24;
  localparam int CW    = 8;
  localparam int T0H   = 7;
  localparam int T1H   = 14;
  localparam int BITC  = 25;
  localparam int UNDC  = 60;
  localparam int RSTC  = 40;
  localparam int NPIX  = 4;
  localparam int WD    = 150000;

  // stimulus word per pixel (lane k at [24k+23:24k]) doubles as expected decode
  localparam logic [LANES*PW-1:0] TBL_DATA [NPIX] = '{
    72'hA5C3F0_000000_FFFFFF,
    72'hFEDCBA_800001_123456,
    72'h5A5A5A_FFFFFF_000000,
    72'h000001_F0F0F0_0F0F0F
  };
  localparam int TBL_STALL [NPIX] = '{0, 3, 17, 40};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, fvalid = 1'b0;
  logic [CW-1:0] pcount = '0;
  logic [LANES*PW-1:0] fdata = '0;
  logic fready, busy, done, undr;
  logic [CW-1:0] fidx;
  logic [LANES-1:0] lane;

  int checks = 0, errors = 0;
  int stall_mode = 0;   // 0 table, 1 random
  logic hang_arm = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_par_driver #(
    .LANES(LANES), .PIX_W(PW), .CNT_W(CW), .T0H(T0H), .T1H(T1H),
    .BIT_CYC(BITC), .UND_CYC(UNDC), .RST_CYC(RSTC)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pix_count_i(pcount),
    .fetch_valid_i(fvalid), .fetch_data_i(fdata), .fetch_ready_o(fready),
    .fetch_idx_o(fidx), .lane_o(lane), .busy_o(busy), .done_o(done),
    .underrun_o(undr)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // source model
  initial begin
    int wcnt, tgt;
    wcnt = 0; tgt = 0;
    forever begin
      @(negedge clk);
      if (!fready) begin
        fvalid = 1'b0;
        wcnt = 0;
      end else begin
        if (wcnt == 0) begin
          if (hang_arm && fidx == 2) tgt = 1000000;
          else if (stall_mode == 1) tgt = $urandom_range(45, 0);
          else tgt = TBL_STALL[fidx];
        end
        if (wcnt >= tgt && !(hang_arm && fidx == 2)) begin
          fvalid = 1'b1;
          fdata = TBL_DATA[fidx];
        end
        wcnt++;
      end
    end
  end

  // monitor: decodes lanes, checks widths, spacing and lockstep
  int cyc = 0;
  int hw [LANES];
  int nb [LANES];
  int pix_l [LANES];
  logic [PW-1:0] sh [LANES];
  logic [PW-1:0] cap [8][LANES];
  int last_rise = 0, ready_rise = 0, und_cyc = 0;
  logic prev0 = 1'b0, prev_busy = 1'b0, prev_ready = 1'b0;

  initial begin
    for (int l = 0; l < LANES; l++) begin
      hw[l] = 0; nb[l] = 0; pix_l[l] = 0; sh[l] = '0;
    end
    forever begin
      @(negedge clk);
      cyc++;
      if (busy && !prev_busy || undr)
        for (int l = 0; l < LANES; l++) begin nb[l] = 0; pix_l[l] = 0; end
      if (undr) und_cyc = cyc;
      if (fready && !prev_ready) ready_rise = cyc;
      if (fready) check(lane == '0, "R5 lanes low while ready", lane, 0);
      if (lane[0] && !prev0) begin
        check(lane == '1, "R4 lockstep rise", lane, (1 << LANES) - 1);
        if (nb[0] != 0) check(cyc - last_rise == BITC, "R2 bit period", cyc - last_rise, BITC);
        last_rise = cyc;
      end
      for (int l = 0; l < LANES; l++) begin
        if (lane[l]) hw[l]++;
        else if (hw[l] != 0) begin
          check(hw[l] == T0H || hw[l] == T1H, "R2/R6 pulse width", hw[l], T0H);
          sh[l] = {sh[l][PW-2:0], (hw[l] == T1H)};
          nb[l]++;
          if (nb[l] == PW) begin
            if (pix_l[l] < 8) cap[pix_l[l]][l] = sh[l];
            pix_l[l]++;
            nb[l] = 0;
          end
          hw[l] = 0;
        end
      end
      prev0 = lane[0];
      prev_busy = busy;
      prev_ready = fready;
    end
  end

  task automatic start_frame(input int n);
    @(negedge clk);
    start = 1'b1; pcount = CW'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done_and_compare(input string tag);
    int guard;
    guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    check(done == 1'b1, "R8 done seen", done, 1);
    check(busy == 1'b0, "R8 busy low with done", busy, 0);
    check(cyc - last_rise == BITC + RSTC - 1, "R8 reset-low length", cyc - last_rise, BITC + RSTC - 1);
    @(negedge clk);
    check(done == 1'b0, "R8 done single cycle", done, 0);
    for (int l = 0; l < LANES; l++) begin
      check(pix_l[l] == NPIX, {"R8 pixel count ", tag}, pix_l[l], NPIX);
      for (int i = 0; i < NPIX; i++)
        check(cap[i][l] == TBL_DATA[i][l*PW +: PW], {"R3 decoded word ", tag},
              cap[i][l], TBL_DATA[i][l*PW +: PW]);
    end
  endtask

  // watchdog
  initial begin
    repeat (WD) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({lane, busy, fready, done, undr} == '0, "R1 outputs in reset", {lane, busy, fready, done, undr}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({lane, busy, fready, done, undr} == '0, "R1 outputs after reset", {lane, busy, fready, done, undr}, 0);

    // frame A: table stalls, plus a start while busy (R9)
    stall_mode = 0;
    start_frame(NPIX);
    check(busy == 1'b1, "R10 busy after start", busy, 1);
    repeat (300) @(negedge clk);
    start = 1'b1; pcount = 8'd1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 busy kept on start while busy", busy, 1);
    wait_done_and_compare("A");

    // frame B: random stalls stretch only gaps (R6)
    stall_mode = 1;
    start_frame(NPIX);
    wait_done_and_compare("B R6");

    // zero count is ignored (R9)
    start_frame(0);
    check(busy == 1'b0, "R9 zero count ignored", busy, 1'b0);
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && fready == 1'b0, "R9 still idle", busy, 0);

    // underrun on pixel 2 then automatic restart (R7)
    stall_mode = 0;
    hang_arm = 1'b1;
    start_frame(NPIX);
    while (!undr) @(negedge clk);
    check(fidx == 8'd2, "R7 underrun on hung pixel", fidx, 2);
    check(cyc - ready_rise == UNDC, "R7 underrun delay", cyc - ready_rise, UNDC);
    hang_arm = 1'b0;
    @(negedge clk);
    while (!fready) begin
      check(lane == '0, "R7 lanes low after underrun", lane, 0);
      @(negedge clk);
    end
    check(cyc - und_cyc == RSTC, "R7 low time before restart", cyc - und_cyc, RSTC);
    check(fidx == 8'd0, "R7 restart index", fidx, 0);
    check(busy == 1'b1, "R10 busy held across restart", busy, 1);
    wait_done_and_compare("R7 retry");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule